// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line). It gives a bus master access to a small file of 8-bit registers. The block samples both bus lines with a system clock that runs at least eight times faster than the bus clock. It then detects start and stop framing and decodes a device-address byte. The second byte of a write sets a register pointer, and every later data byte lands at the pointer, which then steps forward. A read returns bytes from the pointer onward, MSB first. The slave pulls the data line low to acknowledge and to send zero bits. It never drives the line high.

A strap input picks the address the slave answers to. When the strap is low, the slave uses a fixed 7-bit address. When it is high, the slave uses bits 6:0 of the last register in the file, which a write over the bus can change. A register is written only after all eight bits of its byte have arrived, so a byte cut short by a stop or start is dropped. Host logic beside the block has its own read port and write port into the same register file.

Top module: `twr_slave`

## Requirements
- R1: After reset, every register holds 0x00 except the last one (index 15), which holds 0x2B, and the data-line pull-down is off.
- R2: The first byte after a start is a 7-bit address, MSB first, followed by a direction bit (0 = write, 1 = read). With the strap low the address is 0x2B, so 0x56 and 0x57 are acknowledged. An acknowledge is the data line held low during the ninth clock pulse.
- R3: In a write, the second byte loads the pointer from its low 4 bits, and each later byte is written to the pointer and then increments it, with no limit on the count.
- R4: In a read, the slave returns the register at the pointer, MSB first, then the next register on each master acknowledge. A master non-acknowledge ends the read, and the data line is left released.
- R5: The pointer wraps from 15 to 0, for both writes and reads.
- R6: A byte with fewer than 8 bits before a stop changes no register, and registers not yet reached keep their values.
- R7: When the address byte does not match, the slave gives no acknowledge, writes nothing and keeps the line released until the next start or stop.
- R8: With the strap high, the slave answers to the address in bits 6:0 of register 15 and not to the fixed address.
- R9: A repeated start restarts address decoding, and a read that follows returns data from the pointer set earlier in the same transfer.
- R10: The host write port updates a register in the next cycle, and the bus sees the new value. If both ports write the same register in the same cycle, the bus write wins. The host read port returns the current register value.
- R11: Outside of start and stop framing, the slave changes its data-line drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_sel_i | input | 1 | Address strap: 0 fixed address, 1 programmed address |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| host_we_i | input | 1 | Host write enable |
| host_waddr_i | input | 4 | Host write register index |
| host_wdata_i | input | 8 | Host write data |
| host_raddr_i | input | 4 | Host read register index |
| host_rdata_o | output | 8 | Host read data |

## Verification
The bench uses the default build: 16 registers and fixed address 0x2B. With these values the address register is also the last pointer value. A single write starting at index 15 therefore tests both pointer wrap and reprogramming of the address. The bus clock is 16 system clocks per bit, so the synchronizer delay and the acknowledge timing are tested with margin. The fixed address keeps the expected 0x56 and 0x57 bytes easy to read in the bench.

// File: rtl/twr_pkg.sv
package twr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_SKIP
    } twr_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } twr_kind_e;
endpackage

// File: rtl/twr_sync.sv
module twr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = line_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign lvl_o  = sync_q.s2;
    assign rise_o = sync_q.s2 & ~sync_q.prev;
    assign fall_o = ~sync_q.s2 & sync_q.prev;
endmodule

// File: rtl/twr_regfile.sv
module twr_regfile #(
    parameter int          NUM_REGS = 16,
    parameter logic [6:0]  DEF_ADDR = 7'h2B,
    localparam int         PTR_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we_i,
    input  logic [PTR_W-1:0] bus_waddr_i,
    input  logic [7:0]       bus_wdata_i,
    input  logic [PTR_W-1:0] bus_raddr_i,
    output logic [7:0]       bus_rdata_o,
    input  logic             host_we_i,
    input  logic [PTR_W-1:0] host_waddr_i,
    input  logic [7:0]       host_wdata_i,
    input  logic [PTR_W-1:0] host_raddr_i,
    output logic [7:0]       host_rdata_o,
    output logic [6:0]       dev_addr_o
);
    logic [7:0] regs_d [NUM_REGS];
    logic [7:0] regs_q [NUM_REGS];

    always_comb begin
        regs_d = regs_q;
        if (host_we_i) regs_d[host_waddr_i] = host_wdata_i;
        if (bus_we_i)  regs_d[bus_waddr_i]  = bus_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++)
                regs_q[i] <= (i == NUM_REGS - 1) ? {1'b0, DEF_ADDR} : 8'h00;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_rdata_o  = regs_q[bus_raddr_i];
    assign host_rdata_o = regs_q[host_raddr_i];
    assign dev_addr_o   = regs_q[NUM_REGS-1][6:0];

    assert_bus_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && host_we_i && bus_waddr_i == host_waddr_i)
        |=> regs_q[$past(bus_waddr_i)] == $past(bus_wdata_i));

    assert_host_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we_i && !(bus_we_i && bus_waddr_i == host_waddr_i))
        |=> regs_q[$past(host_waddr_i)] == $past(host_wdata_i));
endmodule

// File: rtl/twr_slave.sv
module twr_slave #(
    parameter int         NUM_REGS = 16,
    parameter logic [6:0] DEF_ADDR = 7'h2B,
    localparam int        PTR_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_sel_i,
    output logic             sda_oe_o,
    input  logic             host_we_i,
    input  logic [PTR_W-1:0] host_waddr_i,
    input  logic [7:0]       host_wdata_i,
    input  logic [PTR_W-1:0] host_raddr_i,
    output logic [7:0]       host_rdata_o
);
    import twr_pkg::*;

    typedef struct packed {
        twr_state_e         st;
        twr_kind_e          kind;
        logic [3:0]         cnt;
        logic [BYTE_W-1:0]  sh;
        logic [PTR_W-1:0]   ptr;
        logic               rw;
        logic               seen;
        logic               nack;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, kind: K_ADDR, cnt: 4'd0, sh: '0,
                                 ptr: '0, rw: 1'b0, seen: 1'b0, nack: 1'b0};

    ctl_t ctl_d, ctl_q;

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det;
    logic bus_we;
    logic [7:0] rd_data;
    logic [6:0] dev_addr, my_addr;

    twr_sync u_scl (.clk(clk), .rst_n(rst_n), .line_i(scl_i),
                    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));
    twr_sync u_sda (.clk(clk), .rst_n(rst_n), .line_i(sda_i),
                    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

    twr_regfile #(.NUM_REGS(NUM_REGS), .DEF_ADDR(DEF_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we_i(bus_we), .bus_waddr_i(ctl_q.ptr), .bus_wdata_i(ctl_q.sh),
        .bus_raddr_i(ctl_q.ptr), .bus_rdata_o(rd_data),
        .host_we_i(host_we_i), .host_waddr_i(host_waddr_i), .host_wdata_i(host_wdata_i),
        .host_raddr_i(host_raddr_i), .host_rdata_o(host_rdata_o),
        .dev_addr_o(dev_addr)
    );

    assign start_det = sda_fall & scl_lvl;
    assign stop_det  = sda_rise & scl_lvl;
    assign my_addr   = addr_sel_i ? dev_addr : DEF_ADDR;

    always_comb begin
        ctl_d  = ctl_q;
        bus_we = 1'b0;
        unique case (ctl_q.st)
            ST_RX: begin
                if (scl_rise && ctl_q.cnt != 4'd8) begin
                    ctl_d.sh  = {ctl_q.sh[BYTE_W-2:0], sda_lvl};
                    ctl_d.cnt = ctl_q.cnt + 4'd1;
                end else if (scl_fall && ctl_q.cnt == 4'd8) begin
                    ctl_d.seen = 1'b0;
                    unique case (ctl_q.kind)
                        K_ADDR: begin
                            if (ctl_q.sh[7:1] == my_addr) begin
                                ctl_d.st = ST_ACK;
                                ctl_d.rw = ctl_q.sh[0];
                            end else begin
                                ctl_d.st = ST_SKIP;
                            end
                        end
                        K_PTR: begin
                            ctl_d.ptr = ctl_q.sh[PTR_W-1:0];
                            ctl_d.st  = ST_ACK;
                        end
                        default: begin
                            bus_we    = 1'b1;
                            ctl_d.ptr = ctl_q.ptr + 1'b1;
                            ctl_d.st  = ST_ACK;
                        end
                    endcase
                end
            end
            ST_ACK: begin
                if (scl_rise) begin
                    ctl_d.seen = 1'b1;
                end else if (scl_fall && ctl_q.seen) begin
                    ctl_d.seen = 1'b0;
                    ctl_d.cnt  = 4'd0;
                    if (ctl_q.kind == K_ADDR && ctl_q.rw) begin
                        ctl_d.st  = ST_TX;
                        ctl_d.sh  = rd_data;
                        ctl_d.ptr = ctl_q.ptr + 1'b1;
                    end else begin
                        ctl_d.st   = ST_RX;
                        ctl_d.kind = (ctl_q.kind == K_ADDR) ? K_PTR : K_DATA;
                    end
                end
            end
            ST_TX: begin
                if (scl_rise) begin
                    ctl_d.cnt = ctl_q.cnt + 4'd1;
                end else if (scl_fall) begin
                    if (ctl_q.cnt == 4'd8) begin
                        ctl_d.st   = ST_RACK;
                        ctl_d.seen = 1'b0;
                    end else begin
                        ctl_d.sh = {ctl_q.sh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
            ST_RACK: begin
                if (scl_rise) begin
                    ctl_d.seen = 1'b1;
                    ctl_d.nack = sda_lvl;
                end else if (scl_fall && ctl_q.seen) begin
                    ctl_d.seen = 1'b0;
                    if (ctl_q.nack) begin
                        ctl_d.st = ST_SKIP;
                    end else begin
                        ctl_d.st  = ST_TX;
                        ctl_d.sh  = rd_data;
                        ctl_d.ptr = ctl_q.ptr + 1'b1;
                        ctl_d.cnt = 4'd0;
                    end
                end
            end
            default: ;
        endcase

        if (start_det) begin
            bus_we     = 1'b0;
            ctl_d.st   = ST_RX;
            ctl_d.kind = K_ADDR;
            ctl_d.cnt  = 4'd0;
            ctl_d.seen = 1'b0;
        end else if (stop_det) begin
            bus_we   = 1'b0;
            ctl_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign sda_oe_o = (ctl_q.st == ST_ACK) || (ctl_q.st == ST_TX && !ctl_q.sh[7]);

    // Drive changes only in the low phase of the bus clock.
    assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && !start_det && !stop_det) |-> !scl_lvl);

    // A register write needs a complete 8-bit byte.
    assert_full_byte_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (ctl_q.cnt == 4'd8 && ctl_q.st == ST_RX && ctl_q.kind == K_DATA));

    // Each committed byte steps the pointer by one, modulo the file size.
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> ctl_q.ptr == $past(ctl_q.ptr) + 1'b1);

    // A skipped transfer leaves the line released and stays out of the data path.
    assert_skip_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SKIP && !start_det)
        |=> (ctl_q.st == ST_SKIP || ctl_q.st == ST_IDLE) && !sda_oe_o);

    // A start always restarts address decoding.
    assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (ctl_q.st == ST_RX && ctl_q.kind == K_ADDR && ctl_q.cnt == 4'd0));
endmodule

// File: tb/twr_slave_test.sv
module twr_slave_test;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b0;
    logic       host_we = 1'b0;
    logic [3:0] host_waddr = '0;
    logic [7:0] host_wdata = '0;
    logic [3:0] host_raddr = '0;
    logic [7:0] host_rdata;
    logic       sda_oe;
    wire        sda_bus = sda_m & ~sda_oe;

    int n_checks = 0;
    int n_fail   = 0;
    int r11_viol = 0;

    typedef struct {
        string      tag;
        logic [7:0] val;
    } exp_t;
    exp_t exp_q[$];
    event rd_done;
    logic [7:0] rd_val;

    always #2.5 clk = ~clk;

    twr_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_sel_i(addr_sel), .sda_oe_o(sda_oe),
        .host_we_i(host_we), .host_waddr_i(host_waddr), .host_wdata_i(host_wdata),
        .host_raddr_i(host_raddr), .host_rdata_o(host_rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wq();
        scl_m = 1'b1; wq();
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack = ~sda_bus;
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic read_byte(input logic m_ack);
        logic [7:0] b;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq();
            scl_m = 1'b1; wq();
            b[i] = sda_bus;
            wq();
            scl_m = 1'b0; wq();
        end
        send_bit(~m_ack);
        rd_val = b;
        ->rd_done;
        @(negedge clk);
    endtask

    task automatic wr_chk(input string tag, input logic [7:0] v, input logic exp_ack);
        logic a;
        write_byte(v, a);
        chk(tag, a, exp_ack);
    endtask

    task automatic host_rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
        host_raddr = a;
        @(negedge clk);
        chk(tag, host_rdata, exp);
    endtask

    task automatic expect_rd(input string tag, input logic [7:0] v);
        exp_t e;
        e.tag = tag;
        e.val = v;
        exp_q.push_back(e);
    endtask

    // Scoreboard monitor: compares each byte the master reads.
    initial begin
        forever begin
            @(rd_done);
            if (exp_q.size() == 0) begin
                chk("read with no expected byte", rd_val, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, rd_val, e.val);
            end
        end
    end

    // R11: drive changes while the bus clock is high.
    logic oe_prev = 1'b0;
    always @(posedge clk) begin
        if (rst_n && sda_oe !== oe_prev && scl_m) r11_viol++;
        oe_prev <= sda_oe;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        host_rd("R1 reg0", 4'd0, 8'h00);
        host_rd("R1 reg15", 4'd15, 8'h2B);
        chk("R1 sda released", sda_oe, 0);

        // R2, R3 write 3 bytes from index 2
        bus_start();
        wr_chk("R2 write address ack", 8'h56, 1);
        wr_chk("R3 pointer ack", 8'h02, 1);
        wr_chk("R3 data ack", 8'hA1, 1);
        wr_chk("R3 data ack", 8'hA2, 1);
        wr_chk("R3 data ack", 8'hA3, 1);
        bus_stop();
        host_rd("R3 reg2", 4'd2, 8'hA1);
        host_rd("R3 reg3", 4'd3, 8'hA2);
        host_rd("R3 reg4", 4'd4, 8'hA3);

        // R9, R4 repeated start then read with ack, ack, nack
        bus_start();
        wr_chk("R9 write address ack", 8'h56, 1);
        wr_chk("R9 pointer ack", 8'h02, 1);
        bus_start();
        wr_chk("R2 read address ack", 8'h57, 1);
        expect_rd("R4 read reg2", 8'hA1);
        expect_rd("R4 read reg3", 8'hA2);
        expect_rd("R4 read reg4", 8'hA3);
        read_byte(1'b1);
        read_byte(1'b1);
        read_byte(1'b0);
        wq();
        chk("R4 released after nack", sda_oe, 0);
        bus_stop();

        // R5 wrap on write and read
        bus_start();
        wr_chk("R5 address ack", 8'h56, 1);
        wr_chk("R5 pointer ack", 8'h0F, 1);
        wr_chk("R5 data ack", 8'h2B, 1);
        wr_chk("R5 data ack", 8'h55, 1);
        bus_stop();
        host_rd("R5 reg0 after wrap", 4'd0, 8'h55);
        bus_start();
        wr_chk("R5 address ack", 8'h56, 1);
        wr_chk("R5 pointer ack", 8'h0F, 1);
        bus_start();
        wr_chk("R5 read address ack", 8'h57, 1);
        expect_rd("R5 read reg15", 8'h2B);
        expect_rd("R5 read reg0 after wrap", 8'h55);
        read_byte(1'b1);
        read_byte(1'b0);
        bus_stop();

        // R6 truncated byte before stop
        bus_start();
        wr_chk("R6 address ack", 8'h56, 1);
        wr_chk("R6 pointer ack", 8'h05, 1);
        wr_chk("R6 data ack", 8'h11, 1);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        host_rd("R6 reg5 written", 4'd5, 8'h11);
        host_rd("R6 reg6 unchanged", 4'd6, 8'h00);

        // R7 address mismatch
        bus_start();
        wr_chk("R7 no ack on mismatch", 8'h58, 0);
        wr_chk("R7 no ack after mismatch", 8'h01, 0);
        wr_chk("R7 no ack after mismatch", 8'h77, 0);
        chk("R7 released", sda_oe, 0);
        bus_stop();
        host_rd("R7 reg1 unchanged", 4'd1, 8'h00);

        // R8 programmed address
        bus_start();
        wr_chk("R8 address ack", 8'h56, 1);
        wr_chk("R8 pointer ack", 8'h0F, 1);
        wr_chk("R8 program address", 8'h22, 1);
        bus_stop();
        addr_sel = 1'b1;
        bus_start();
        wr_chk("R8 programmed address ack", 8'h44, 1);
        wr_chk("R8 pointer ack", 8'h08, 1);
        wr_chk("R8 data ack", 8'h5A, 1);
        bus_stop();
        host_rd("R8 reg8", 4'd8, 8'h5A);
        bus_start();
        wr_chk("R8 fixed address ignored", 8'h56, 0);
        bus_stop();
        bus_start();
        wr_chk("R8 programmed address ack", 8'h44, 1);
        wr_chk("R8 pointer ack", 8'h0F, 1);
        wr_chk("R8 restore address", 8'h2B, 1);
        bus_stop();
        addr_sel = 1'b0;

        // R10 host write seen by the bus
        host_waddr = 4'd7;
        host_wdata = 8'h9C;
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
        host_rd("R10 host readback", 4'd7, 8'h9C);
        bus_start();
        wr_chk("R10 address ack", 8'h56, 1);
        wr_chk("R10 pointer ack", 8'h07, 1);
        bus_start();
        wr_chk("R10 read address ack", 8'h57, 1);
        expect_rd("R10 bus read of host write", 8'h9C);
        read_byte(1'b0);
        bus_stop();

        repeat (8) @(negedge clk);
        chk("R11 drive changes with clock high", r11_viol, 0);
        chk("scoreboard drained", exp_q.size(), 0);

        summary();
        $finish;
    end
endmodule